// File: doc/BRIEF.md
# Masked Interrupt Controller with Status Latching

This block collects interrupt lines from peripherals and turns them into one interrupt request for a small processor core. Each line owns one bit in a status register, which records that the line fired. It also owns one bit in a mask register, which decides whether a recorded event may interrupt the core. The request also depends on the core's global interrupt-enable input, and it changes only at instruction boundaries. Software reaches both registers through a small register port. Writes to the mask replace it. Writes to the status can only clear bits.

Parameters set the trigger style (edge or level), whether the two lowest lines are non-maskable, and whether the controller is present at all. When it is absent, the registers stay at zero and any raised line goes straight to the request, gated only by the global enable. Every new line assertion also produces a one-cycle wake pulse, which the power manager uses to drop doze and sleep modes. An assertion on a line that is already pending is dropped, and a flag reports the drop.

Top module: `irq_mask_ctl`

## Requirements
- R1: After reset the status register reads 0, the mask reads 0x3 when non-maskable lines are configured and 0 otherwise, and `cpu_irq` and `wake_pulse` are low.
- R2: In edge mode, a 0-to-1 transition on line n sets status bit n at the next clock. In level mode, status bit n is set at each clock while line n is high.
- R3: A 0-to-1 transition on a line whose status bit is already set leaves the status unchanged and is not remembered. `irq_drop` is high during that same cycle and low for a transition on a line whose bit is clear.
- R4: At a clock where `insn_done` is high, `cpu_irq` takes the value `gie` AND (mask AND status is nonzero).
- R5: A mask write or a rise of `gie` that exposes a pending unmasked bit raises `cpu_irq` at the next instruction boundary. No new line event is needed.
- R6: In edge mode a status bit stays set until software clears it. In level mode a status bit clears at the first clock where its line is low.
- R7: Each clock edge that samples a 0-to-1 transition on any line is followed by exactly one cycle of `wake_pulse` high.
- R8: With the controller disabled, both registers read 0 and ignore writes, and the request at each instruction boundary is `gie` AND (any line high).
- R9: `ctl_present` is 1 when the controller is enabled and 0 when it is bypassed.
- R10: `cpu_irq` keeps its value on every clock where `insn_done` is low.
- R11: With non-maskable lines configured, mask bits 1:0 always read 1, even after a write of 0.
- R12: A status write (`reg_sel`=1) ANDs the register with `reg_wdata`: a 0 clears a bit and a 1 keeps it. In level mode, a line that is still high sets its bit again at the next clock. `reg_sel`=0 selects the mask, and `reg_rdata` shows the selected register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_line | input | N_LINES | Peripheral interrupt lines |
| gie | input | 1 | Core global interrupt enable |
| insn_done | input | 1 | Core instruction boundary strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Selected register contents |
| cpu_irq | output | 1 | Interrupt request to the core |
| irq_drop | output | 1 | A new assertion hit an already pending line |
| wake_pulse | output | 1 | One-cycle pulse that clears doze and sleep modes |
| ctl_present | output | 1 | Controller present flag for the unit-present register |

## Verification
The bench walks every line of an 8-line configuration in edge, level and bypass builds at once. It checks set, hold and clear for each line, so a design that decodes a line to the wrong bit or lets level bits linger is caught. Re-asserting a pending line checks the drop flag and that nothing is queued. A controller that counts repeats would need extra clears. Mask writes and a late `gie` rise check that a waiting interrupt fires without a new event. Holding `insn_done` low shows whether the request ignores instruction boundaries. A write of 0 to the mask checks that the non-maskable bits are kept.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register selector on the software port
  typedef enum logic {
    IRQC_SEL_MASK = 1'b0,
    IRQC_SEL_STAT = 1'b1
  } irqc_sel_e;

  // Number of lowest lines treated as non-maskable when that option is on
  localparam int IRQC_NMI_LINES = 2;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] prev_o,
  output logic               wake_o
);

  logic [N_LINES-1:0] prev_q;
  logic               wake_q;
  logic               wake_d;
  logic               any_rise;

  always_comb begin
    any_rise = |(line_i & ~prev_q);
    wake_d   = any_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      wake_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      wake_q <= wake_d;
    end
  end

  assign prev_o = prev_q;
  assign wake_o = wake_q;

  // R7
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(line_i & ~prev_o)) |=> wake_o);

  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(line_i & ~prev_o))) |=> !wake_o);

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_LINES   = 32,
  parameter bit EDGE_TRIG = 1'b1,
  parameter bit NMI_EN    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic [N_LINES-1:0] line_i,
  input  logic [N_LINES-1:0] prev_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] stat_o,
  output logic               drop_o
);

  localparam logic [N_LINES-1:0] FORCE_ON = NMI_EN ?
    {{(N_LINES-IRQC_NMI_LINES){1'b0}}, {IRQC_NMI_LINES{1'b1}}} : '0;

  logic [N_LINES-1:0] mask_q, mask_d;
  logic [N_LINES-1:0] stat_q, stat_d;
  logic [N_LINES-1:0] rise;
  logic               mask_we;
  logic               stat_we;
  irqc_sel_e          sel;

  assign sel     = irqc_sel_e'(sel_i);
  assign mask_we = we_i & (sel == IRQC_SEL_MASK);
  assign stat_we = we_i & (sel == IRQC_SEL_STAT);
  assign rise    = line_i & ~prev_i;

  // Mask next state: non-maskable positions are forced on
  always_comb begin
    mask_d = mask_q;
    if (mask_we) begin
      mask_d = wdata_i | FORCE_ON;
    end
  end

  // Status next state per line, variant chosen by trigger mode
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic kept;
    assign kept = stat_we ? (stat_q[i] & wdata_i[i]) : stat_q[i];
    if (EDGE_TRIG) begin : g_edge
      assign stat_d[i] = kept | rise[i];
    end else begin : g_level
      assign stat_d[i] = (stat_we ? kept : (kept | line_i[i])) & line_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= FORCE_ON;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign drop_o = |(rise & stat_q);

  if (NMI_EN) begin : g_nmi_chk
    // R11
    nmi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_o[IRQC_NMI_LINES-1:0] == {IRQC_NMI_LINES{1'b1}});
  end

  if (EDGE_TRIG) begin : g_edge_chk
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && sel_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
  end else begin : g_level_chk
    // R6
    level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o & ~$past(line_i)) == '0);
  end

endmodule

// File: rtl/irqc_req.sv
module irqc_req (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic gie_i,
  input  logic boundary_i,
  output logic req_o
);

  logic req_q;
  logic req_d;

  always_comb begin
    req_d = req_q;
    if (boundary_i) begin
      req_d = gie_i & pend_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (boundary_i) begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(req_o));

  // R4
  req_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !gie_i) |=> !req_o);

endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irqc_pkg::*;
#(
  parameter int N_LINES   = 32,
  parameter bit EDGE_TRIG = 1'b1,
  parameter bit NMI_EN    = 1'b0,
  parameter bit CTRL_EN   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_line,
  input  logic               gie,
  input  logic               insn_done,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               cpu_irq,
  output logic               irq_drop,
  output logic               wake_pulse,
  output logic               ctl_present
);

  logic               rst_n_s;
  logic [N_LINES-1:0] prev;
  logic [N_LINES-1:0] mask;
  logic [N_LINES-1:0] stat;
  logic               pend;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  irqc_detect #(.N_LINES(N_LINES)) u_det (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .line_i (irq_line),
    .prev_o (prev),
    .wake_o (wake_pulse)
  );

  if (CTRL_EN) begin : g_ctl
    irqc_regs #(
      .N_LINES   (N_LINES),
      .EDGE_TRIG (EDGE_TRIG),
      .NMI_EN    (NMI_EN)
    ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .we_i    (reg_we),
      .sel_i   (reg_sel),
      .wdata_i (reg_wdata),
      .line_i  (irq_line),
      .prev_i  (prev),
      .mask_o  (mask),
      .stat_o  (stat),
      .drop_o  (irq_drop)
    );
    assign pend = |(mask & stat);
  end else begin : g_bypass
    assign mask     = '0;
    assign stat     = '0;
    assign irq_drop = 1'b0;
    assign pend     = |irq_line;
  end

  irqc_req u_req (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pend_i     (pend),
    .gie_i      (gie),
    .boundary_i (insn_done),
    .req_o      (cpu_irq)
  );

  always_comb begin
    reg_rdata = (irqc_sel_e'(reg_sel) == IRQC_SEL_STAT) ? stat : mask;
  end

  assign ctl_present = CTRL_EN;

  // R3
  drop_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_drop |-> (stat != '0));

endmodule

// File: tb/sim_irq_mask_ctl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctl;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] irq;
  logic         gie;
  logic         insn;
  logic         we;
  logic         sel;
  logic [N-1:0] wd;

  logic [N-1:0] rd0, rd1, rd2;
  logic         req0, req1, req2;
  logic         drop0, drop1, drop2;
  logic         wake0, wake1, wake2;
  logic         pres0, pres1, pres2;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Edge triggered, non-maskable lines on
  irq_mask_ctl #(.N_LINES(N), .EDGE_TRIG(1'b1), .NMI_EN(1'b1), .CTRL_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_line(irq), .gie(gie), .insn_done(insn),
    .reg_we(we), .reg_sel(sel), .reg_wdata(wd), .reg_rdata(rd0),
    .cpu_irq(req0), .irq_drop(drop0), .wake_pulse(wake0), .ctl_present(pres0));

  // Level triggered, no non-maskable lines
  irq_mask_ctl #(.N_LINES(N), .EDGE_TRIG(1'b0), .NMI_EN(1'b0), .CTRL_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_line(irq), .gie(gie), .insn_done(insn),
    .reg_we(we), .reg_sel(sel), .reg_wdata(wd), .reg_rdata(rd1),
    .cpu_irq(req1), .irq_drop(drop1), .wake_pulse(wake1), .ctl_present(pres1));

  // Controller bypassed
  irq_mask_ctl #(.N_LINES(N), .EDGE_TRIG(1'b1), .NMI_EN(1'b0), .CTRL_EN(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .irq_line(irq), .gie(gie), .insn_done(insn),
    .reg_we(we), .reg_sel(sel), .reg_wdata(wd), .reg_rdata(rd2),
    .cpu_irq(req2), .irq_drop(drop2), .wake_pulse(wake2), .ctl_present(pres2));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [N-1:0] d);
    we = 1'b1; sel = s; wd = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [N-1:0] a0, output logic [N-1:0] a1,
                    output logic [N-1:0] a2);
    sel = s;
    #1;
    a0 = rd0; a1 = rd1; a2 = rd2;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m0, m1, m2, s0, s1, s2;
    rst_n = 1'b0; irq = '0; gie = 1'b0; insn = 1'b1;
    we = 1'b0; sel = 1'b0; wd = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state, R9 presence
    rd(1'b0, m0, m1, m2);
    rd(1'b1, s0, s1, s2);
    chk("R1 mask nmi", m0, 8'h03);
    chk("R1 mask plain", m1, 8'h00);
    chk("R1 status", s0, 8'h00);
    chk("R1 status level", s1, 8'h00);
    chk("R1 req", {req0, req1, req2}, 3'b000);
    chk("R1 wake", {wake0, wake1, wake2}, 3'b000);
    chk("R9 present", {pres0, pres1, pres2}, 3'b110);

    // Per-line sweep: R2, R4, R6, R7, R8
    gie = 1'b1;
    for (int n = 0; n < N; n++) begin
      logic [N-1:0] b;
      b = N'(1) << n;
      irq = b;
      #1;
      chk("R3 no drop on fresh line", {31'b0, drop0}, 0);
      tick();
      rd(1'b1, s0, s1, s2);
      chk("R2 edge set", s0, b);
      chk("R2 level set", s1, b);
      chk("R8 bypass status", s2, 0);
      chk("R7 wake", {wake0, wake1, wake2}, 3'b111);
      chk("R8 bypass req", {31'b0, req2}, 1);
      irq = '0;
      tick();
      rd(1'b1, s0, s1, s2);
      chk("R6 edge hold", s0, b);
      chk("R6 level clear", s1, 0);
      chk("R7 wake single", {wake0, wake1, wake2}, 3'b000);
      chk("R4 nmi lines only", {31'b0, req0}, (n < 2) ? 1 : 0);
      chk("R8 bypass req drop", {31'b0, req2}, 0);
      wr(1'b1, ~b);
      rd(1'b1, s0, s1, s2);
      chk("R12 status clear", s0, 0);
      tick();
      chk("R4 req after clear", {31'b0, req0}, 0);
    end

    // Mask and enable: R4, R5, R11, R8, R12
    gie = 1'b0;
    wr(1'b0, 8'hFF);
    rd(1'b0, m0, m1, m2);
    chk("R12 mask write", m0, 8'hFF);
    chk("R8 bypass mask ignores write", m2, 0);
    irq = 8'hFF;
    tick();
    irq = '0;
    tick();
    rd(1'b1, s0, s1, s2);
    chk("R2 all lines", s0, 8'hFF);
    chk("R4 gie low", {31'b0, req0}, 0);
    chk("R8 bypass gie low", {31'b0, req2}, 0);
    tick();
    chk("R4 gie low held", {31'b0, req0}, 0);
    gie = 1'b1;
    tick();
    chk("R5 gie rise", {31'b0, req0}, 1);
    wr(1'b0, 8'h00);
    rd(1'b0, m0, m1, m2);
    chk("R11 nmi kept", m0, 8'h03);
    chk("R12 mask zero plain", m1, 8'h00);
    tick();
    chk("R4 nmi pending", {31'b0, req0}, 1);
    wr(1'b1, 8'hFC);
    rd(1'b1, s0, s1, s2);
    chk("R12 and write", s0, 8'hFC);
    tick();
    chk("R4 masked pending", {31'b0, req0}, 0);
    wr(1'b0, 8'h10);
    chk("R5 before boundary", {31'b0, req0}, 0);
    tick();
    chk("R5 mask write", {31'b0, req0}, 1);

    // Dropped repeat: R3
    irq = 8'h10;
    #1;
    chk("R3 drop flag", {31'b0, drop0}, 1);
    chk("R3 bypass drop", {31'b0, drop2}, 0);
    tick();
    irq = '0;
    rd(1'b1, s0, s1, s2);
    chk("R3 status unchanged", s0, 8'hFC);
    wr(1'b1, 8'hEF);
    rd(1'b1, s0, s1, s2);
    chk("R3 not queued", s0, 8'hEC);
    tick();
    rd(1'b1, s0, s1, s2);
    chk("R3 still clear", s0, 8'hEC);
    chk("R3 drop low", {31'b0, drop0}, 0);

    // Instruction boundary: R10
    wr(1'b1, 8'h00);
    tick();
    chk("R4 cleared", {31'b0, req0}, 0);
    wr(1'b0, 8'h20);
    insn = 1'b0;
    irq = 8'h20;
    tick();
    irq = '0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 wait boundary", {31'b0, req0}, 0);
    end
    insn = 1'b1;
    tick();
    chk("R10 boundary raise", {31'b0, req0}, 1);
    insn = 1'b0;
    wr(1'b1, 8'h00);
    tick();
    tick();
    chk("R10 held", {31'b0, req0}, 1);
    insn = 1'b1;
    tick();
    chk("R10 boundary drop", {31'b0, req0}, 0);

    // Level re-set after software clear: R12
    irq = 8'h04;
    tick();
    tick();
    rd(1'b1, s0, s1, s2);
    chk("R2 level held", s1, 8'h04);
    wr(1'b1, 8'hFB);
    rd(1'b1, s0, s1, s2);
    chk("R12 level cleared", s1, 8'h00);
    chk("R12 edge cleared", s0, 8'h00);
    tick();
    rd(1'b1, s0, s1, s2);
    chk("R12 level re-set", s1, 8'h04);
    chk("R6 edge no re-set", s0, 8'h00);
    irq = '0;
    tick();
    rd(1'b1, s0, s1, s2);
    chk("R6 level drop", s1, 8'h00);

    done = 1;
    summary();
    $finish;
  end

endmodule